// File: doc/BRIEF.md
# Microcode Queue Sequencer

This block sequences a byte-wide processor that spends exactly one clock on each micro-operation. Each opcode read from memory is expanded, through a computed lookup, into a short list of micro-operations that is appended to a circular queue. The queue is drained one entry per clock. Every list ends with an opcode-fetch entry, so the queue never runs dry.

The sequencer drives a 16-bit address bus, a read strobe, a write strobe and an 8-bit write-data bus. Read data comes back in the same cycle. It keeps the program counter, the stack pointer, the current opcode, the last data byte and the effective address. When a fetch begins, it raises an execute pulse carrying the previous opcode and its data byte, so an external ALU can finish that instruction while the next opcode is being read. Index registers and the status byte arrive as inputs. A pulse tells the status owner to set the interrupt-mask flag.

An indexed read spends an extra correction cycle only when adding the index carries into the high address byte. When there is no carry, the queued correction entry is overwritten by a fetch and the cycle disappears.

Top module: `mq_seq`

## Requirements
- R1: In the first cycle after reset, the block reads address 0x0000 as an opcode, with the execute pulse and the mask pulse low. The stack pointer starts at 0xFF, so the first push writes 0x01FF.
- R2: A fetch reads at PC, advances PC by one and latches the opcode. In that same cycle the execute pulse is high and carries the opcode and data byte of the instruction before, which is never the opcode being read now.
- R3: Every opcode other than 0x00, 0x01, 0x05, 0x0D, 0x11, 0x19 and 0x1D takes one cycle, so the next fetch reads PC+1 in the following clock.
- R4: Opcode 0x05 (zero page) reads the operand at PC+1, then reads 0x00nn, then fetches; the execute data is the byte read at 0x00nn.
- R5: Opcode 0x0D (absolute) reads the low and high operand bytes, then reads {high,low}, then fetches.
- R6: Opcode 0x01 (pre-indexed indirect) reads the operand p, makes a dummy read at 0x00p, then reads the pointer from 0x00((p+X) mod 256) and 0x00((p+X+1) mod 256), both wrapping inside page zero. It then reads {high,low} and fetches.
- R7: Opcodes 0x1D (X) and 0x19 (Y), absolute indexed, read at {high, low+index}. When the 8-bit sum has no carry, the next fetch follows directly, for 4 cycles in all.
- R8: When the indexed sum carries, the first data read uses the uncorrected high byte and a second read uses high+1. This takes 5 cycles, and the execute data comes from the second read.
- R9: Opcode 0x11 (post-indexed indirect) reads the pointer from 0x00p and 0x00(p+1), adds Y to the pointer's low byte, and follows the same carry and skip rule as R7 and R8.
- R10: Opcode 0x00 (break) reads a padding byte at PC+1. It then writes PC high, PC low and (status OR 0x30) to 0x0100+SP, with SP decreasing by one after each write. The mask pulse is high in the status-write cycle. The block then loads PC low from 0xFF00+0xFE and PC high from 0xFFFF, and fetches from the loaded PC.
- R11: The read and write strobes are never high together, and writes happen only during stack pushes.
- R12: The queue is a 256-entry ring. Every fetch is the last queued entry, and sequencing stays correct after the ring pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_idx | input | 8 | X index value |
| y_idx | input | 8 | Y index value |
| status_in | input | 8 | Current status byte, used by the push |
| rdata | input | 8 | Read data, valid in the same cycle |
| addr | output | 16 | Address bus |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| wdata | output | 8 | Write data |
| exec_pulse | output | 1 | Finish-previous-instruction pulse |
| exec_opcode | output | 8 | Opcode being finished |
| exec_data | output | 8 | Data byte for the finishing opcode |
| set_irq_mask | output | 1 | Request to set the interrupt-mask flag |

## Verification
Two things share one clock edge: finishing the old instruction and starting the new one. The execute pulse for the old opcode falls in the same cycle as the new opcode read. Back-to-back instructions provoke this. The check requires the execute outputs to show the previous opcode and data byte while the address bus already shows the new fetch address. A second overlap is the skip decision, which rewrites the queue entry that would otherwise run next. Indexed reads with and without a page carry exercise both paths, and the check counts the cycles before the next fetch.

// File: rtl/mq_pkg.sv
package mq_pkg;

  localparam int UW   = 4;
  localparam int MAXL = 7;
  localparam int LW   = 3;

  typedef enum logic [UW-1:0] {
    U_FETCH     = 4'd0,
    U_OPLO      = 4'd1,
    U_OPHI      = 4'd2,
    U_OPHI_X    = 4'd3,
    U_OPHI_Y    = 4'd4,
    U_PUSH_PCH  = 4'd5,
    U_PUSH_PCL  = 4'd6,
    U_PUSH_ST   = 4'd7,
    U_VEC_LO    = 4'd8,
    U_VEC_HI    = 4'd9,
    U_IDX_X     = 4'd10,
    U_PTR_LO    = 4'd11,
    U_PTR_HI    = 4'd12,
    U_PTR_HI_Y  = 4'd13,
    U_READ      = 4'd14,
    U_READ_SKIP = 4'd15
  } uop_e;

  typedef logic [MAXL-1:0][UW-1:0] ulist_t;

  typedef struct packed {
    logic [LW-1:0] len;
    ulist_t        ops;
  } uprog_t;

  // 8-bit add that keeps the carry in bit 8
  function automatic logic [8:0] idx_add(input logic [7:0] a, input logic [7:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [15:0] page_addr(input logic [7:0] page, input logic [7:0] off);
    return {page, off};
  endfunction

  // Opcode -> micro-op list; unlisted opcodes become a lone fetch
  function automatic uprog_t decode(input logic [7:0] op);
    uprog_t r;
    r.len = LW'(1);
    r.ops = '0;
    case (op)
      8'h00: begin
        r.len = LW'(7);
        r.ops[0] = U_OPLO;     r.ops[1] = U_PUSH_PCH; r.ops[2] = U_PUSH_PCL;
        r.ops[3] = U_PUSH_ST;  r.ops[4] = U_VEC_LO;   r.ops[5] = U_VEC_HI;
        r.ops[6] = U_FETCH;
      end
      8'h01: begin
        r.len = LW'(6);
        r.ops[0] = U_OPLO;   r.ops[1] = U_IDX_X; r.ops[2] = U_PTR_LO;
        r.ops[3] = U_PTR_HI; r.ops[4] = U_READ;  r.ops[5] = U_FETCH;
      end
      8'h05: begin
        r.len = LW'(3);
        r.ops[0] = U_OPLO; r.ops[1] = U_READ; r.ops[2] = U_FETCH;
      end
      8'h0D: begin
        r.len = LW'(4);
        r.ops[0] = U_OPLO; r.ops[1] = U_OPHI; r.ops[2] = U_READ; r.ops[3] = U_FETCH;
      end
      8'h11: begin
        r.len = LW'(6);
        r.ops[0] = U_OPLO;      r.ops[1] = U_PTR_LO; r.ops[2] = U_PTR_HI_Y;
        r.ops[3] = U_READ_SKIP; r.ops[4] = U_READ;   r.ops[5] = U_FETCH;
      end
      8'h19: begin
        r.len = LW'(5);
        r.ops[0] = U_OPLO; r.ops[1] = U_OPHI_Y; r.ops[2] = U_READ_SKIP;
        r.ops[3] = U_READ; r.ops[4] = U_FETCH;
      end
      8'h1D: begin
        r.len = LW'(5);
        r.ops[0] = U_OPLO; r.ops[1] = U_OPHI_X; r.ops[2] = U_READ_SKIP;
        r.ops[3] = U_READ; r.ops[4] = U_FETCH;
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mq_uop_rom.sv
module mq_uop_rom
  import mq_pkg::*;
(
  input  logic [7:0]    opcode,
  output logic [LW-1:0] list_len,
  output ulist_t        list_ops
);
  uprog_t prog;
  always_comb begin
    prog     = decode(opcode);
    list_len = prog.len;
    list_ops = prog.ops;
  end
endmodule

// File: rtl/mq_queue.sv
module mq_queue
  import mq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          app_en,
  input  logic [LW-1:0] app_len,
  input  ulist_t        app_ops,
  input  logic          trunc_en,
  output uop_e          head,
  output logic [AW-1:0] used
);
  localparam int DEPTH = 1 << AW;

  logic [UW-1:0] ring [DEPTH];
  logic [AW-1:0] rptr, wptr, nxt;
  logic [AW-1:0] slot [MAXL];

  for (genvar k = 0; k < MAXL; k++) begin : g_slot
    assign slot[k] = wptr + AW'(k);
  end

  assign nxt  = rptr + AW'(1);
  assign head = uop_e'(ring[rptr]);
  assign used = wptr - rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= U_FETCH;
      rptr <= '0;
      wptr <= AW'(1);
    end else begin
      rptr <= nxt;
      if (app_en) begin
        for (int k = 0; k < MAXL; k++)
          if (k < int'(app_len)) ring[slot[k]] <= app_ops[k];
        wptr <= wptr + AW'(app_len);
      end else if (trunc_en) begin
        ring[nxt] <= U_FETCH;
        wptr      <= nxt + AW'(1);
      end
    end
  end
endmodule

// File: rtl/mq_bus_mux.sv
module mq_bus_mux
  import mq_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] VEC_PAGE   = 8'hFF,
  parameter logic [7:0] VEC_IDX    = 8'hFE
) (
  input  uop_e        uop,
  input  logic [15:0] pc,
  input  logic [7:0]  sp,
  input  logic [15:0] ad,
  input  logic [7:0]  status_in,
  output logic [15:0] addr,
  output logic        rd_en,
  output logic        wr_en,
  output logic [7:0]  wdata,
  output logic        mask_set
);
  localparam logic [7:0] VEC_IDX_HI = VEC_IDX + 8'd1;
  localparam logic [7:0] PUSH_BITS  = 8'h30;

  always_comb begin
    addr     = ad;
    rd_en    = 1'b1;
    wr_en    = 1'b0;
    wdata    = 8'h00;
    mask_set = 1'b0;
    case (uop)
      U_FETCH, U_OPLO, U_OPHI, U_OPHI_X, U_OPHI_Y: addr = pc;
      U_PUSH_PCH: begin
        addr = page_addr(STACK_PAGE, sp); rd_en = 1'b0; wr_en = 1'b1; wdata = pc[15:8];
      end
      U_PUSH_PCL: begin
        addr = page_addr(STACK_PAGE, sp); rd_en = 1'b0; wr_en = 1'b1; wdata = pc[7:0];
      end
      U_PUSH_ST: begin
        addr = page_addr(STACK_PAGE, sp); rd_en = 1'b0; wr_en = 1'b1;
        wdata = status_in | PUSH_BITS; mask_set = 1'b1;
      end
      U_VEC_LO: addr = page_addr(VEC_PAGE, VEC_IDX);
      U_VEC_HI: addr = page_addr(VEC_PAGE, VEC_IDX_HI);
      default:  addr = ad;
    endcase
  end
endmodule

// File: rtl/mq_seq.sv
module mq_seq
  import mq_pkg::*;
#(
  parameter int          Q_AW       = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  VEC_PAGE   = 8'hFF,
  parameter logic [7:0]  VEC_IDX    = 8'hFE,
  parameter logic [7:0]  SP_RESET   = 8'hFF,
  parameter logic [15:0] PC_RESET   = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  x_idx,
  input  logic [7:0]  y_idx,
  input  logic [7:0]  status_in,
  input  logic [7:0]  rdata,
  output logic [15:0] addr,
  output logic        rd_en,
  output logic        wr_en,
  output logic [7:0]  wdata,
  output logic        exec_pulse,
  output logic [7:0]  exec_opcode,
  output logic [7:0]  exec_data,
  output logic        set_irq_mask
);
  uop_e            uop;
  logic [LW-1:0]   list_len;
  ulist_t          list_ops;
  logic [Q_AW-1:0] q_used;

  logic [15:0] pc_q, ad_q;
  logic [7:0]  sp_q, opc_q, data_q, tmp_q;
  logic        carry_q, have_op_q;

  // named events for the checker
  logic fetch_ev, skip_ev, push_ev;
  logic [8:0] sum_x, sum_y, sum_p;

  assign fetch_ev = (uop == U_FETCH);
  assign skip_ev  = (uop == U_READ_SKIP) && !carry_q;
  assign push_ev  = (uop == U_PUSH_PCH) || (uop == U_PUSH_PCL) || (uop == U_PUSH_ST);
  assign sum_x    = idx_add(ad_q[7:0], x_idx);
  assign sum_y    = idx_add(ad_q[7:0], y_idx);
  assign sum_p    = idx_add(tmp_q, y_idx);

  mq_uop_rom u_rom (
    .opcode   (rdata),
    .list_len (list_len),
    .list_ops (list_ops)
  );

  mq_queue #(.AW(Q_AW)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .app_en   (fetch_ev),
    .app_len  (list_len),
    .app_ops  (list_ops),
    .trunc_en (skip_ev),
    .head     (uop),
    .used     (q_used)
  );

  mq_bus_mux #(
    .STACK_PAGE (STACK_PAGE),
    .VEC_PAGE   (VEC_PAGE),
    .VEC_IDX    (VEC_IDX)
  ) u_bus (
    .uop       (uop),
    .pc        (pc_q),
    .sp        (sp_q),
    .ad        (ad_q),
    .status_in (status_in),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .mask_set  (set_irq_mask)
  );

  assign exec_pulse  = fetch_ev && have_op_q;
  assign exec_opcode = opc_q;
  assign exec_data   = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= PC_RESET;
      sp_q      <= SP_RESET;
      opc_q     <= '0;
      data_q    <= '0;
      tmp_q     <= '0;
      ad_q      <= '0;
      carry_q   <= 1'b0;
      have_op_q <= 1'b0;
    end else begin
      case (uop)
        U_FETCH: begin
          opc_q     <= rdata;
          pc_q      <= pc_q + 16'd1;
          have_op_q <= 1'b1;
        end
        U_OPLO: begin
          ad_q    <= {8'h00, rdata};
          data_q  <= rdata;
          carry_q <= 1'b0;
          pc_q    <= pc_q + 16'd1;
        end
        U_OPHI: begin
          ad_q[15:8] <= rdata;
          pc_q       <= pc_q + 16'd1;
        end
        U_OPHI_X: begin
          ad_q    <= {rdata, sum_x[7:0]};
          carry_q <= sum_x[8];
          pc_q    <= pc_q + 16'd1;
        end
        U_OPHI_Y: begin
          ad_q    <= {rdata, sum_y[7:0]};
          carry_q <= sum_y[8];
          pc_q    <= pc_q + 16'd1;
        end
        U_PUSH_PCH, U_PUSH_PCL, U_PUSH_ST: sp_q <= sp_q - 8'd1;
        U_VEC_LO:   pc_q[7:0]  <= rdata;
        U_VEC_HI:   pc_q[15:8] <= rdata;
        U_IDX_X:    ad_q[7:0]  <= sum_x[7:0];
        U_PTR_LO: begin
          tmp_q     <= rdata;
          ad_q[7:0] <= ad_q[7:0] + 8'd1;
        end
        U_PTR_HI:   ad_q <= {rdata, tmp_q};
        U_PTR_HI_Y: begin
          ad_q    <= {rdata, sum_p[7:0]};
          carry_q <= sum_p[8];
        end
        U_READ:     data_q <= rdata;
        U_READ_SKIP: begin
          data_q <= rdata;
          if (carry_q) begin
            ad_q[15:8] <= ad_q[15:8] + 8'd1;
            carry_q    <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mq_seq_chk.sv
module mq_seq_chk #(
  parameter int         Q_AW       = 8,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic            wr_en,
  input logic [15:0]     addr,
  input logic            exec_pulse,
  input logic            set_irq_mask,
  input logic            fetch_ev,
  input logic            skip_ev,
  input logic            push_ev,
  input logic [Q_AW-1:0] q_used,
  input logic [15:0]     pc_q,
  input logic [7:0]      sp_q
);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_write_on_stack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (addr[15:8] == STACK_PAGE) && push_ev);

  p_exec_at_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> fetch_ev && rd_en);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |=> pc_q == $past(pc_q) + 16'd1);

  p_fetch_is_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |-> q_used == Q_AW'(1));

  p_skip_to_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_ev |=> fetch_ev);

  p_sp_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> sp_q == $past(sp_q) - 8'd1);

  p_mask_with_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_irq_mask |-> wr_en);
endmodule

bind mq_seq mq_seq_chk #(.Q_AW(Q_AW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .addr         (addr),
  .exec_pulse   (exec_pulse),
  .set_irq_mask (set_irq_mask),
  .fetch_ev     (fetch_ev),
  .skip_ev      (skip_ev),
  .push_ev      (push_ev),
  .q_used       (q_used),
  .pc_q         (pc_q),
  .sp_q         (sp_q)
);

// File: tb/sim_mq_seq.sv
`timescale 1ns/1ps
module sim_mq_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  x_idx = '0, y_idx = '0, status_in = '0;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic        rd_en, wr_en, exec_pulse, set_irq_mask;
  logic [7:0]  wdata, exec_opcode, exec_data;

  logic [7:0] mem [4096];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rdata = mem[addr[11:0]];

  mq_seq u0 (
    .clk(clk), .rst_n(rst_n), .x_idx(x_idx), .y_idx(y_idx), .status_in(status_in),
    .rdata(rdata), .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .exec_pulse(exec_pulse), .exec_opcode(exec_opcode), .exec_data(exec_data),
    .set_irq_mask(set_irq_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // check bus of the current cycle, then advance one clock
  task automatic cyc(input string tag, input logic rd, input logic wr,
                     input logic [15:0] a, input logic [7:0] wd);
    chk(tag, {6'd0, rd_en, wr_en, addr, (wr_en ? wdata : 8'h00)},
             {6'd0, rd, wr, a, wd});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic exq(input string tag, input logic p, input logic [7:0] op, input logic [7:0] d);
    if (p) chk(tag, {15'd0, exec_pulse, exec_opcode, exec_data}, {15'd0, p, op, d});
    else   chk(tag, {31'd0, exec_pulse}, 32'd0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h02;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    clear_mem();
    do_reset();
    exq("R1 exec low after reset", 0, 0, 0);
    chk("R1 mask low after reset", {31'd0, set_irq_mask}, 32'd0);
    cyc("R1 first fetch at 0", 1, 0, 16'h0000, 0);
  endtask

  task automatic t_undef();
    clear_mem();
    mem[0] = 8'h02; mem[1] = 8'hFF; mem[2] = 8'h03;
    do_reset();
    cyc("R3 fetch 0", 1, 0, 16'h0000, 0);
    exq("R2 exec previous 02", 1, 8'h02, 8'h00);
    cyc("R3 fetch 1", 1, 0, 16'h0001, 0);
    exq("R2 exec previous FF", 1, 8'hFF, 8'h00);
    cyc("R3 fetch 2", 1, 0, 16'h0002, 0);
  endtask

  task automatic t_zp();
    clear_mem();
    mem[0] = 8'h05; mem[1] = 8'h80; mem[12'h080] = 8'h3C;
    do_reset();
    cyc("R4 fetch", 1, 0, 16'h0000, 0);
    cyc("R4 operand", 1, 0, 16'h0001, 0);
    cyc("R4 data read", 1, 0, 16'h0080, 0);
    exq("R2 exec overlaps next fetch", 1, 8'h05, 8'h3C);
    cyc("R4 next fetch", 1, 0, 16'h0002, 0);
  endtask

  task automatic t_abs();
    clear_mem();
    mem[0] = 8'h0D; mem[1] = 8'h34; mem[2] = 8'h12; mem[12'h234] = 8'h77;
    do_reset();
    cyc("R5 fetch", 1, 0, 16'h0000, 0);
    cyc("R5 lo", 1, 0, 16'h0001, 0);
    cyc("R5 hi", 1, 0, 16'h0002, 0);
    cyc("R5 data", 1, 0, 16'h1234, 0);
    exq("R5 exec data", 1, 8'h0D, 8'h77);
    cyc("R5 next fetch", 1, 0, 16'h0003, 0);
  endtask

  task automatic t_pre();
    clear_mem();
    x_idx = 8'hF0;
    mem[0] = 8'h01; mem[1] = 8'h0F; mem[12'h0FF] = 8'h40; mem[12'h140] = 8'h5E;
    do_reset();
    cyc("R6 fetch", 1, 0, 16'h0000, 0);
    cyc("R6 operand", 1, 0, 16'h0001, 0);
    cyc("R6 dummy", 1, 0, 16'h000F, 0);
    cyc("R6 ptr lo", 1, 0, 16'h00FF, 0);
    cyc("R6 ptr hi wraps", 1, 0, 16'h0000, 0);
    cyc("R6 data", 1, 0, 16'h0140, 0);
    exq("R6 exec data", 1, 8'h01, 8'h5E);
    cyc("R6 next fetch", 1, 0, 16'h0002, 0);
  endtask

  task automatic t_absx();
    clear_mem();
    x_idx = 8'h20;
    mem[0] = 8'h1D; mem[1] = 8'h10; mem[2] = 8'h03; mem[12'h330] = 8'hA1;
    do_reset();
    cyc("R7 fetch", 1, 0, 16'h0000, 0);
    cyc("R7 lo", 1, 0, 16'h0001, 0);
    cyc("R7 hi", 1, 0, 16'h0002, 0);
    cyc("R7 data no carry", 1, 0, 16'h0330, 0);
    exq("R7 exec data", 1, 8'h1D, 8'hA1);
    cyc("R7 skip to fetch", 1, 0, 16'h0003, 0);
  endtask

  task automatic t_absy_cross();
    clear_mem();
    y_idx = 8'h20;
    mem[0] = 8'h19; mem[1] = 8'hF0; mem[2] = 8'h03;
    mem[12'h310] = 8'h11; mem[12'h410] = 8'hC7;
    do_reset();
    cyc("R8 fetch", 1, 0, 16'h0000, 0);
    cyc("R8 lo", 1, 0, 16'h0001, 0);
    cyc("R8 hi", 1, 0, 16'h0002, 0);
    cyc("R8 uncorrected read", 1, 0, 16'h0310, 0);
    cyc("R8 corrected read", 1, 0, 16'h0410, 0);
    exq("R8 exec data", 1, 8'h19, 8'hC7);
    cyc("R8 next fetch", 1, 0, 16'h0003, 0);
  endtask

  task automatic t_post();
    clear_mem();
    y_idx = 8'h50;
    mem[0] = 8'h11; mem[1] = 8'h40; mem[12'h040] = 8'hC0; mem[12'h041] = 8'h05;
    mem[12'h510] = 8'h22; mem[12'h610] = 8'h6B;
    do_reset();
    cyc("R9 fetch", 1, 0, 16'h0000, 0);
    cyc("R9 operand", 1, 0, 16'h0001, 0);
    cyc("R9 ptr lo", 1, 0, 16'h0040, 0);
    cyc("R9 ptr hi", 1, 0, 16'h0041, 0);
    cyc("R9 uncorrected", 1, 0, 16'h0510, 0);
    cyc("R9 corrected", 1, 0, 16'h0610, 0);
    exq("R9 exec data", 1, 8'h11, 8'h6B);
    cyc("R9 next fetch", 1, 0, 16'h0002, 0);
  endtask

  task automatic t_brk();
    clear_mem();
    status_in = 8'h81;
    mem[0] = 8'h00; mem[1] = 8'hEE; mem[12'hFFE] = 8'h34; mem[12'hFFF] = 8'h0C;
    mem[12'hC34] = 8'h00;
    do_reset();
    cyc("R10 fetch", 1, 0, 16'h0000, 0);
    cyc("R10 padding", 1, 0, 16'h0001, 0);
    cyc("R1 R10 push pc hi at 01FF", 0, 1, 16'h01FF, 8'h00);
    cyc("R10 push pc lo", 0, 1, 16'h01FE, 8'h02);
    chk("R10 mask pulse", {31'd0, set_irq_mask}, 32'd1);
    cyc("R10 push status", 0, 1, 16'h01FD, 8'hB1);
    chk("R10 mask pulse ends", {31'd0, set_irq_mask}, 32'd0);
    cyc("R10 vector lo", 1, 0, 16'hFFFE, 0);
    cyc("R10 vector hi", 1, 0, 16'hFFFF, 0);
    cyc("R10 fetch at vector", 1, 0, 16'h0C34, 0);
    cyc("R10 second padding", 1, 0, 16'h0C35, 0);
    cyc("R10 sp continues", 0, 1, 16'h01FC, 8'h0C);
  endtask

  task automatic t_wrap();
    clear_mem();
    for (int i = 0; i < 100; i++) begin
      mem[2*i] = 8'h05; mem[2*i+1] = 8'hD0 + 8'(i % 16);
    end
    for (int j = 0; j < 16; j++) mem[12'h0D0 + j] = 8'h30 + 8'(j);
    do_reset();
    for (int i = 0; i < 100; i++) begin
      if (i > 0) exq("R12 exec across ring", 1, 8'h05, 8'h30 + 8'((i-1) % 16));
      cyc("R12 fetch", 1, 0, 16'(2*i), 0);
      cyc("R12 operand", 1, 0, 16'(2*i+1), 0);
      cyc("R12 data", 1, 0, 16'h00D0 + 16'(i % 16), 0);
    end
    cyc("R12 tail fetch", 1, 0, 16'd200, 0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_undef();
    t_zp();
    t_abs();
    t_pre();
    t_absx();
    t_absy_cross();
    t_post();
    t_brk();
    t_wrap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule